// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Set and Clear

This block is a general-purpose I/O port for custom logic, reached over a small synchronous register bus. A data register drives the output pins when written and returns the synchronized levels of the input pins when read. An optional pair of atomic registers, one write-one-to-set and one write-one-to-clear, changes chosen output bits in a single bus write. This removes the need for a read-modify-write sequence and the race that sequence carries.

The port width is a parameter (8, 16, 32 or 64), and each bit is one GPIO line. A second parameter selects how lines map to register bits. In the normal order, line n is bit n. In the reversed order, line n is bit width-1-n, so line 0 sits at the most significant bit. There is no direction control. A line counts as an output once a value is written to it, and software gets no effect from marking a line as an input.

Bus access uses a two-bit word index. Index 0 is the data register, index 1 is the set register, index 2 is the clear register, and index 3 is unused. Each write is taken in one cycle.

Top module: `gpio_mmio`

## Requirements
- R1: While `rst` is high, at each rising edge the output latch clears to all zeros, so `pin_out` reads zero. The input synchronizer also clears, so a read of index 0 returns zero during reset whatever the pins do.
- R2: A write (`bus_wr`=1) to index 0 loads `bus_wdata` into the output latch. `pin_out` shows the new value after the next rising edge.
- R3: When set and clear are present (`HAS_SETCLR`=1), a write to index 1 forces to 1 every latch bit whose written bit is 1. All other bits keep their value.
- R4: When set and clear are present, a write to index 2 forces to 0 every latch bit whose written bit is 1. All other bits keep their value.
- R5: `bus_rdata` is zero whenever `bus_addr` is 1, 2 or 3. The read path is combinational from the current address.
- R6: While `bus_addr` is 0, `bus_rdata` returns the `pin_in` levels that were present two rising edges earlier, arranged in register bit order. A pin looped back to its output therefore shows a data write in the read value two cycles after `pin_out` changes.
- R7: With `REVERSED`=0, line n (`pin_out[n]`, `pin_in[n]`) maps to register bit n. With `REVERSED`=1, line n maps to register bit WIDTH-1-n. The same mapping applies to writes and to reads.
- R8: When set and clear are absent (`HAS_SETCLR`=0), writes to index 1 and index 2 leave the output latch unchanged.
- R9: A write to index 3 leaves the latch unchanged. A cycle with `bus_wr`=0 also leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word index: 0 data, 1 set, 2 clear, 3 unused |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | WIDTH | Write data, in register bit order |
| bus_rdata | output | WIDTH | Read data, in register bit order |
| pin_in | input | WIDTH | External GPIO input levels, in line order |
| pin_out | output | WIDTH | GPIO output drive, in line order |

## Verification
The assertions check the following on every cycle:
- the latch result of data, set and clear writes;
- that idle, unused-index and (without set/clear) set/clear writes leave the latch unchanged;
- the zero read on non-data indices;
- the two-edge latency from the pins to the read path;
- the clear state after reset.

Only the bench scenarios can show that line-to-bit numbering is correct in both orders. The same holds for a looped-back reversed port returning exactly the word written, and for long random mixes of set, clear and data writes matching an independent model of the latch.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;

    localparam int unsigned BUS_ADDR_W = 2;

    typedef enum logic [BUS_ADDR_W-1:0] {
        SEL_DATA  = 2'd0,
        SEL_SET   = 2'd1,
        SEL_CLEAR = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    function automatic bit width_is_legal(int unsigned w);
        return (w == 8) || (w == 16) || (w == 32) || (w == 64);
    endfunction

endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
    parameter int unsigned WIDTH    = 32,
    parameter bit          REVERSED = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);

    // The mapping is its own inverse, so one module serves both directions.
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        if (REVERSED) begin : g_rev
            assign dst[i] = src[WIDTH-1-i];
        end else begin : g_fwd
            assign dst[i] = src[i];
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/gpio_latch_regs.sv
module gpio_latch_regs
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned WIDTH      = 32,
    parameter bit          HAS_SETCLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_DATA:  st_d.latch = wr_data;
                SEL_SET:   if (HAS_SETCLR) st_d.latch = st_q.latch | wr_data;
                SEL_CLEAR: if (HAS_SETCLR) st_d.latch = st_q.latch & ~wr_data;
                default:   st_d.latch = st_q.latch;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch = st_q.latch;

    // R2: a data write loads the written word
    p_data_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_DATA) |=> (latch == $past(wr_data)));

    // R9: idle cycles and spare-index writes keep the latch
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_sel == SEL_SPARE) |=> $stable(latch));

    if (HAS_SETCLR) begin : g_setclr_chk
        // R3: every written one becomes a one
        p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SEL_SET) |=>
                ((latch & $past(wr_data)) == $past(wr_data)) &&
                ((latch & ~$past(wr_data)) == ($past(latch) & ~$past(wr_data))));
        // R4: every written one becomes a zero
        p_clear_bits_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == SEL_CLEAR) |=>
                ((latch & $past(wr_data)) == '0) &&
                ((latch & ~$past(wr_data)) == ($past(latch) & ~$past(wr_data))));
    end else begin : g_plain_chk
        // R8: set/clear indices do nothing when absent
        p_absent_setclr_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_sel == SEL_SET || wr_sel == SEL_CLEAR)) |=> $stable(latch));
    end

endmodule

// File: rtl/gpio_mmio.sv
module gpio_mmio
    import gpio_mmio_pkg::*;
#(
    parameter int unsigned WIDTH      = 32,
    parameter bit          REVERSED   = 1'b0,
    parameter bit          HAS_SETCLR = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      pin_out
);

    localparam int unsigned SYNC_STAGES = 2;

    if (!width_is_legal(WIDTH)) begin : g_bad_width
        $error("gpio_mmio: WIDTH must be 8, 16, 32 or 64");
    end

    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_regorder;
    logic [WIDTH-1:0] pins_synced;
    logic [WIDTH-1:0] pins_regorder;

    assign sel = reg_sel_e'(bus_addr);

    gpio_latch_regs #(
        .WIDTH      (WIDTH),
        .HAS_SETCLR (HAS_SETCLR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .latch   (latch_regorder)
    );

    gpio_bit_order #(
        .WIDTH    (WIDTH),
        .REVERSED (REVERSED)
    ) u_out_map (
        .src (latch_regorder),
        .dst (pin_out)
    );

    gpio_in_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pins_synced)
    );

    gpio_bit_order #(
        .WIDTH    (WIDTH),
        .REVERSED (REVERSED)
    ) u_in_map (
        .src (pins_synced),
        .dst (pins_regorder)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel == SEL_DATA) begin
            bus_rdata = pins_regorder;
        end
    end

    // Cycles since reset, used only to gate the latency check.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R1: reset clears the drive
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pin_out == '0));

    // R5: non-data indices read as zero
    p_rd_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (sel != SEL_DATA) |-> (bus_rdata == '0));

    // R6: synchronizer output is the pin level two edges back
    p_sync_latency_r6: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (pins_synced == $past(pin_in, 2)));

endmodule

// File: tb/sim_gpio_mmio.sv
module sim_gpio_mmio;

    localparam int unsigned W0 = 16;
    localparam int unsigned W1 = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    int checks = 0;
    int errors = 0;

    // u0: 16 bits, normal order, set/clear present, pins driven by bench
    logic [1:0]    a0 = '0;
    logic          w0 = 1'b0;
    logic [W0-1:0] d0 = '0;
    logic [W0-1:0] r0;
    logic [W0-1:0] pi0 = '0;
    logic [W0-1:0] po0;

    // u1: 8 bits, reversed order, no set/clear, pins looped back
    logic [1:0]    a1 = '0;
    logic          w1 = 1'b0;
    logic [W1-1:0] d1 = '0;
    logic [W1-1:0] r1;
    logic [W1-1:0] po1;

    gpio_mmio #(.WIDTH(W0), .REVERSED(1'b0), .HAS_SETCLR(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_addr(a0), .bus_wr(w0), .bus_wdata(d0),
        .bus_rdata(r0), .pin_in(pi0), .pin_out(po0));

    gpio_mmio #(.WIDTH(W1), .REVERSED(1'b1), .HAS_SETCLR(1'b0)) u1 (
        .clk(clk), .rst(rst), .bus_addr(a1), .bus_wr(w1), .bus_wdata(d1),
        .bus_rdata(r1), .pin_in(po1), .pin_out(po1));

    function automatic logic [W1-1:0] rev8(logic [W1-1:0] v);
        logic [W1-1:0] o;
        for (int i = 0; i < int'(W1); i++) o[i] = v[W1-1-i];
        return o;
    endfunction

    function automatic logic [W0-1:0] model_next(logic [W0-1:0] cur, logic wr,
                                                 logic [1:0] adr, logic [W0-1:0] dat);
        if (!wr) return cur;
        case (adr)
            2'd0:    return dat;
            2'd1:    return cur | dat;
            2'd2:    return cur & ~dat;
            default: return cur;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic u1_write(logic [1:0] adr, logic [W1-1:0] dat);
        @(negedge clk);
        a1 = adr; w1 = 1'b1; d1 = dat;
        @(negedge clk);
        w1 = 1'b0; a1 = 2'd0;
        #1;
    endtask

    logic done = 1'b0;

    initial begin
        logic [W0-1:0] exp0;
        logic [W0-1:0] h1, h2;
        logic [1:0]    op_adr;
        logic          op_wr;
        logic [W0-1:0] op_dat;
        void'($urandom(32'd1234));

        // R1: reset state with all pins high
        pi0 = '1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 pin_out u0", po0, 0);
        check("R1 rdata u0", r0, 0);
        check("R1 pin_out u1", po1, 0);
        @(negedge clk);
        rst = 1'b0;

        // R7 / R6: reversed looped-back port, line n <-> bit 7-n
        u1_write(2'd0, 8'h01);
        check("R7 u1 bit0 drives line 7", po1, 8'h80);
        @(negedge clk); @(negedge clk); #1;
        check("R6 u1 loopback read", r1, 8'h01);
        u1_write(2'd0, 8'hC5);
        check("R7 u1 reversed drive", po1, rev8(8'hC5));
        @(negedge clk); @(negedge clk); #1;
        check("R6 u1 loopback read 2", r1, 8'hC5);
        u1_write(2'd1, 8'hFF);
        check("R8 u1 set ignored", po1, rev8(8'hC5));
        u1_write(2'd2, 8'hFF);
        check("R8 u1 clear ignored", po1, rev8(8'hC5));
        u1_write(2'd3, 8'h00);
        check("R9 u1 spare ignored", po1, rev8(8'hC5));
        a1 = 2'd1; #1;
        check("R5 u1 set index reads zero", r1, 0);
        a1 = 2'd0;

        // Directed u0 corners: set then clear on a known value
        @(negedge clk); a0 = 2'd0; w0 = 1'b1; d0 = 16'h00F0;
        @(negedge clk); a0 = 2'd1; d0 = 16'h8001; #1;
        check("R2 u0 data write", po0, 16'h00F0);
        @(negedge clk); a0 = 2'd2; d0 = 16'h0030; #1;
        check("R3 u0 set", po0, 16'h80F1);
        @(negedge clk); w0 = 1'b0; a0 = 2'd2; #1;
        check("R4 u0 clear", po0, 16'h80C1);
        check("R5 u0 clear index reads zero", r0, 0);
        exp0 = 16'h80C1;

        // Random mix on u0 with random pins
        h1 = pi0; h2 = pi0;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            op_wr  = ($urandom_range(0, 3) != 0);
            op_adr = 2'($urandom_range(0, 3));
            op_dat = 16'($urandom);
            a0 = op_adr; w0 = op_wr; d0 = op_dat;
            h2 = h1; h1 = pi0;
            pi0 = 16'($urandom);
            #1;
            check("R2/R3/R4/R9 u0 latch", po0, exp0);
            check("R7 u0 normal order", po0[3], exp0[3]);
            if (n >= 2) begin
                if (op_adr == 2'd0) check("R6 u0 pin read latency", r0, h2);
                else                check("R5 u0 non-data read zero", r0, 0);
            end
            exp0 = model_next(exp0, op_wr, op_adr, op_dat);
        end
        @(negedge clk); w0 = 1'b0; #1;
        check("R2/R3/R4 u0 final latch", po0, exp0);
        @(negedge clk); #1;
        check("R9 u0 idle hold", po0, exp0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule